// File: doc/BRIEF.md
# Event Timestamp Latch

This block records the value of a free-running 32-bit time counter at the moment a trigger occurs. The trigger comes from one of two sources. The first is a chosen edge of an asynchronous event pin, which passes through a synchronizer before edge detection. The second is a synchronous internal trigger pulse. There is a single capture channel.

Software reaches the block through a small 16-bit register window. Address 0 holds the configuration. Address 1 is the status word, and addresses 2 and 3 return the low and high halves of the latched time. Software polls the status word until it shows a capture, then reads both timestamp halves. It then writes the status word back with the valid bit cleared, which re-arms the channel.

A flag records events that arrive while a timestamp is still unread. An overwrite option decides whether such an event replaces the stored time. A saturating sequence counter counts the triggers that are seen. Any write to the status word sets that counter back to zero.

Top module: `evt_stamp_cap`

## Requirements
- R1: After reset, every readable word is zero: configuration, status, and both timestamp halves.
- R2: Rising-edge capture of the pin:
  - This applies when configuration bit 0 is 0 and the source bit is 0.
  - A rising edge on the pin latches `time_cnt` at the second clock edge after the clock edge that first samples the new pin level.
  - The same capture sets status bit 15 (valid).
- R3: With configuration bit 0 set to 1, a falling edge of the pin triggers capture and a rising edge is ignored.
- R4: Status bit 13 selects the trigger source:
  - When bit 13 is 1, a high `int_trig` at a clock edge captures the `time_cnt` value present at that edge, and pin edges are ignored.
  - When bit 13 is 0, `int_trig` is ignored.
- R5: A status write with bit 15 at 0 clears valid. Writing bit 15 as 1 never sets it. A trigger after the clear captures again.
- R6: Error flag, status bit 14:
  - A trigger that arrives while valid is 1 sets bit 14.
  - Bit 14 stays set until a status write with bit 14 at 0.
- R7: With configuration bit 1 (overwrite) at 0, a trigger while valid is 1 keeps the stored timestamp.
- R8: With configuration bit 1 at 1, a trigger while valid is 1 replaces the stored timestamp.
- R9: Sequence counter, status bits [CW-1:0]:
  - When configuration bit 2 is 1, the counter increments on every trigger and saturates at 2^CW-1.
  - When configuration bit 2 is 0, the counter holds its value.
- R10: Any write to address 1 resets the sequence counter to zero and loads the source bit from write-data bit 13.
- R11: Register map and read-back:
  - Address 0 reads the configuration in bits [2:0] and zero in the other bits.
  - Address 2 reads timestamp bits [15:0].
  - Address 3 reads timestamp bits [31:16].
  - Status bits between bit 13 and the counter read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_cnt | input | TW | Free-running time counter to sample |
| evt_pin | input | 1 | Asynchronous event-request pin |
| int_trig | input | 1 | Synchronous internal trigger pulse |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data for `addr` (combinational) |

## Verification
The bench builds the block with a 4-bit sequence counter. With that width, saturation at 15 is reached within a short burst of internal triggers, and the counter's full range is exercised again in the random phase. The time counter starts just below a 16-bit boundary, so captured values cross from one high word to the next. Random steps mix configuration changes, status write-backs, pin toggles and internal pulses. After every step, the readback is compared against a model driven by these event rules.

// File: rtl/evt_stamp_cap.sv
module evt_stamp_cap #(
  parameter int TW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_cnt,
  input  logic          evt_pin,
  input  logic          int_trig,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam int PADW = 13 - CW;

  logic [2:0]    sync_q;
  logic [2:0]    cfg_q;
  logic          src_q, valid_q, err_q;
  logic [TW-1:0] ts_q;
  logic [CW-1:0] cnt_q;

  wire rose    = sync_q[1] & ~sync_q[2];
  wire fell    = ~sync_q[1] & sync_q[2];
  wire pin_ev  = cfg_q[0] ? fell : rose;
  wire ev      = src_q ? int_trig : pin_ev;
  wire cfg_wr  = wr_en && addr == 2'd0;
  wire stat_wr = wr_en && addr == 2'd1;
  wire unused_wd = ^wr_data[12:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cfg_q   <= '0;
      src_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      ts_q    <= '0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[1:0], evt_pin};
      if (cfg_wr) cfg_q <= wr_data[2:0];
      if (stat_wr) src_q <= wr_data[13];

      if (ev) valid_q <= 1'b1;
      else if (stat_wr) valid_q <= valid_q & wr_data[15];

      if (ev && valid_q) err_q <= 1'b1;
      else if (stat_wr) err_q <= err_q & wr_data[14];

      if (ev && (!valid_q || cfg_q[1])) ts_q <= time_cnt;

      if (stat_wr) cnt_q <= '0;
      else if (ev && cfg_q[2] && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {13'd0, cfg_q};
      2'd1:    rd_data = {valid_q, err_q, src_q, {PADW{1'b0}}, cnt_q};
      2'd2:    rd_data = ts_q[15:0];
      default: rd_data = ts_q[TW-1:16];
    endcase
  end
endmodule

// File: rtl/evt_stamp_cap_chk.sv
module evt_stamp_cap_chk #(
  parameter int TW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] time_cnt,
  input logic          int_trig,
  input logic [1:0]    addr,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [2:0]    cfg_q,
  input logic          src_q,
  input logic          valid_q,
  input logic          err_q,
  input logic [TW-1:0] ts_q,
  input logic [CW-1:0] cnt_q
);
  wire swr = wr_en && addr == 2'd1;

  p_stat_wr_clears_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> cnt_q == '0);

  p_cnt_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !swr |=> cnt_q >= $past(cnt_q));

  p_int_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q && int_trig && !valid_q) |=> (valid_q && ts_q == $past(time_cnt)));

  p_keep_old_ts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !cfg_q[1]) |=> $stable(ts_q));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(swr && !wr_data[14])) |=> err_q);
endmodule

bind evt_stamp_cap evt_stamp_cap_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt), .int_trig(int_trig),
  .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q),
  .src_q(src_q), .valid_q(valid_q), .err_q(err_q), .ts_q(ts_q), .cnt_q(cnt_q)
);

// File: tb/evt_stamp_cap_test.sv
module evt_stamp_cap_test;
  localparam int CLK_NS = 10;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, evt_pin = 0, int_trig = 0, wr_en = 0;
  logic [31:0] tc = 32'h0001_FFE0;
  logic [1:0] addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  logic m_valid = 0, m_err = 0, m_src = 0, m_fall = 0, m_ovr = 0, m_cen = 0, pin_lvl = 0;
  logic [31:0] m_ts = 0;
  logic [CW-1:0] m_cnt = 0;

  evt_stamp_cap #(.TW(32), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .time_cnt(tc), .evt_pin(evt_pin), .int_trig(int_trig),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) tc <= tc + 1;

  function automatic logic [15:0] exp_stat();
    return {m_valid, m_err, m_src, {(13-CW){1'b0}}, m_cnt};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setcfg(input logic f, input logic o, input logic c);
    wr(2'd0, {13'd0, c, o, f});
    m_fall = f; m_ovr = o; m_cen = c;
  endtask

  task automatic wst(input logic v, input logic e, input logic s);
    wr(2'd1, {v, e, s, 13'd0});
    m_valid &= v; m_err &= e; m_src = s; m_cnt = '0;
  endtask

  task automatic m_event(input logic [31:0] t);
    if (m_cen && m_cnt != {CW{1'b1}}) m_cnt++;
    if (!m_valid) begin m_ts = t; m_valid = 1; end
    else begin m_err = 1; if (m_ovr) m_ts = t; end
  endtask

  task automatic step(input logic p, input logic it);
    logic [31:0] t0;
    t0 = tc;
    evt_pin = p; int_trig = it;
    @(negedge clk);
    int_trig = 0;
    repeat (3) @(negedge clk);
    if (m_src && it) m_event(t0);
    if (!m_src && p != pin_lvl && (p ? !m_fall : m_fall)) m_event(t0 + 2);
    pin_lvl = p;
  endtask

  task automatic check_all(input string req);
    logic [15:0] v;
    rd(2'd1, v); chk(req, {16'd0, v}, {16'd0, exp_stat()});
    rd(2'd2, v); chk(req, {16'd0, v}, {16'd0, m_ts[15:0]});
    rd(2'd3, v); chk(req, {16'd0, v}, {16'd0, m_ts[31:16]});
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 cfg", {16'd0, v}, 0);
    check_all("R1");

    setcfg(0, 0, 1);
    rd(2'd0, v); chk("R11 cfg readback", {16'd0, v}, 32'h4);
    step(1, 0); check_all("R2 rising capture");
    step(0, 0); check_all("R3 falling ignored when rising selected");
    step(1, 0); check_all("R7 keep old ts, R6 error");
    wst(0, 1, 0); check_all("R5 clear valid, R10 cnt reset, R6 err kept");
    wst(0, 0, 0); check_all("R6 err cleared");

    setcfg(0, 1, 1);
    step(0, 0); step(1, 0); check_all("R5 recapture");
    step(0, 0); step(1, 0); check_all("R8 overwrite");

    wst(0, 0, 0); setcfg(1, 0, 1);
    step(0, 0); check_all("R3 falling capture");
    step(1, 0); check_all("R3 rising ignored");

    wst(0, 0, 1);
    step(0, 0); step(1, 0); check_all("R4 pin ignored when internal");
    step(1, 1); check_all("R4 internal capture");
    wst(0, 0, 0);
    step(1, 1); check_all("R4 int_trig ignored when external");

    setcfg(1, 1, 1); wst(0, 0, 1);
    for (int i = 0; i < 20; i++) step(pin_lvl, 1);
    check_all("R9 saturation");
    setcfg(1, 1, 0); wst(0, 0, 1);
    step(pin_lvl, 1); step(pin_lvl, 1); check_all("R9 counting disabled");
    wst(0, 0, 1); check_all("R10 status write");

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) setcfg(1'($urandom), 1'($urandom), 1'($urandom));
      else if (r == 1) wst(1'($urandom), 1'($urandom), 1'($urandom));
      else step(1'($urandom), 1'($urandom));
      check_all("R2-random R9-random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule